// File: doc/BRIEF.md
# Dual External Interrupt Sense Unit

This block watches a small set of external interrupt pins (two by default) and turns pin activity into interrupt requests. Each input has its own two-bit sense selector that chooses between low-level sensing, falling-edge sensing and rising-edge sensing, plus one code that disables triggering. Each input also has an enable bit. The request is based only on the pin value, whatever drives the pin. Firmware can therefore set off an interrupt by driving the pin itself.

Edge sensing runs in the I/O clock domain. Each pin goes through a synchronizer and a history flop. A detected edge sets a sticky flag, and software clears that flag with a write-one-to-clear strobe. An input `io_clk_run_i` says whether the I/O clock is running. While it is low, the edge logic is frozen and sees nothing. Low-level sensing is a purely combinational path from the pin to the request, so it still works while the clock is halted. The wake-up output is the OR of all requests, and a sleep controller uses it to restart the part. The block has no data stream, so every port is a plain control or status signal with no handshake.

Top module: `xint_detector`

## Requirements
- R1: While reset is asserted and straight after it is released, every edge flag reads 0. With all enables at 0, every request and the wake-up output read 0.
- R2: With sense code 00 (low level), the request equals enable AND NOT pin. It follows the pin combinationally with no clock edge, it also works while `io_clk_run_i` is 0, and it drops as soon as the pin returns high (it is not latched).
- R3: With sense code 10 (falling edge), a 1-to-0 pin transition sets the channel flag on the third rising clock edge after the change, counting the edge that first samples it. A 0-to-1 transition sets nothing.
- R4: With sense code 11 (rising edge), a 0-to-1 pin transition sets the flag with the same three-edge latency. A 1-to-0 transition sets nothing.
- R5: With sense code 01, the channel never sets its flag and its request stays 0, whatever the pin does.
- R6: An edge flag stays set until a clear strobe (`flag_clr_i` bit 1 for one cycle) is applied. The flag then reads 0 after that clock edge.
- R7: If an edge is detected in the same cycle as a clear strobe for that channel, the flag stays set.
- R8: While `io_clk_run_i` is 0, no edge is detected. An edge that happens during the halt is not flagged after the clock resumes. Edge detection works again once three running cycles have refilled the synchronizer.
- R9: In edge modes the request equals enable AND flag. With the enable at 0 the flag still records edges but the request stays 0.
- R10: `wake_o` is 1 exactly when any channel's request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_clk_run_i | input | 1 | 1 while the I/O clock is running |
| pin_i | input | N_CH | Raw external interrupt pins |
| en_i | input | N_CH | Per-channel request enable |
| sense_i | input | 2*N_CH | Sense code per channel, channel k in bits [2k+1:2k] |
| flag_clr_i | input | N_CH | Write-one-to-clear strobe per channel flag |
| flag_o | output | N_CH | Sticky edge flags |
| irq_o | output | N_CH | Per-channel interrupt requests |
| wake_o | output | 1 | Wake-up request, OR of all requests |

## Verification
Each channel is driven through both pin transitions under each sense code. This separates falling-edge, rising-edge, disabled and level behaviour, and checks the flag in the cycle before and the cycle of the expected set, which pins down the synchronizer latency. A clear strobe is lined up with a fresh edge so that set-wins ordering can be told apart from clear-wins. The pin is moved during a clock halt and then held, which separates a detector that really freezes from one that catches the halted edge after resume. Level mode is checked with no clock edge between pin change and sample, with the clock halted, which proves the request path is asynchronous and not latched.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_OFF  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/xint_edge_sync.sv
module xint_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pin_i,
  output logic cur_o,
  output logic prev_o,
  output logic valid_o
);
  localparam int FILL_MAX = STAGES + 1;
  localparam int FW       = $clog2(FILL_MAX + 1);

  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic [FW-1:0]     fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      fill_q <= '0;
    end else if (run_i) begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      hist_q <= sync_q[STAGES-1];
      if (fill_q != FW'(FILL_MAX)) fill_q <= fill_q + 1'b1;
    end else begin
      fill_q <= '0;
    end
  end

  assign cur_o   = sync_q[STAGES-1];
  assign prev_o  = hist_q;
  assign valid_o = run_i && (fill_q == FW'(FILL_MAX));

  // R8: a halted cycle forces a refill before detection resumes
  a_r8_refill_after_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !valid_o);
endmodule

// File: rtl/xint_channel.sv
module xint_channel
  import xint_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  sense_e sense_i,
  input  logic   pin_i,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   valid_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   irq_o
);
  logic hit;
  logic flag_q;

  always_comb begin
    hit = 1'b0;
    if (valid_i) begin
      unique case (sense_i)
        SENSE_FALL: hit = prev_i && !cur_i;
        SENSE_RISE: hit = !prev_i && cur_i;
        default:    hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  irq_o = en_i && !pin_i;
      SENSE_FALL,
      SENSE_RISE: irq_o = en_i && flag_q;
      default:    irq_o = 1'b0;
    endcase
  end

  assign flag_o = flag_q;

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> flag_q);
  a_r5_off_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_OFF && !flag_q) |=> !flag_q);
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

// File: rtl/xint_detector.sv
module xint_detector
  import xint_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_clk_run_i,
  input  logic [N_CH-1:0]   pin_i,
  input  logic [N_CH-1:0]   en_i,
  input  logic [2*N_CH-1:0] sense_i,
  input  logic [N_CH-1:0]   flag_clr_i,
  output logic [N_CH-1:0]   flag_o,
  output logic [N_CH-1:0]   irq_o,
  output logic              wake_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic cur, prev, valid;

    xint_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (io_clk_run_i),
      .pin_i   (pin_i[g]),
      .cur_o   (cur),
      .prev_o  (prev),
      .valid_o (valid)
    );

    xint_channel u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i[g]),
      .sense_i (sense_e'(sense_i[2*g +: 2])),
      .pin_i   (pin_i[g]),
      .cur_i   (cur),
      .prev_i  (prev),
      .valid_i (valid),
      .clr_i   (flag_clr_i[g]),
      .flag_o  (flag_o[g]),
      .irq_o   (irq_o[g])
    );
  end

  assign wake_o = |irq_o;

  a_r10_wake_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> wake_o);
  a_r10_wake_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == '0) |-> !wake_o);
endmodule

// File: tb/xint_detector_tb.sv
module xint_detector_tb_top;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b1;
  logic [N-1:0] pin = '1;
  logic [N-1:0] en = '0;
  logic [2*N-1:0] sense = 4'b1010;
  logic [N-1:0] clr = '0;
  logic [N-1:0] flag, irq;
  logic         wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string        tag;
    logic [N-1:0] flag;
    logic [N-1:0] irq;
    logic         wake;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  xint_detector #(.N_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_clk_run_i(run), .pin_i(pin),
    .en_i(en), .sense_i(sense), .flag_clr_i(clr),
    .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  task automatic expect_out(string tag, logic [N-1:0] f, logic [N-1:0] i, logic w);
    exp_t e;
    e.tag = tag; e.flag = f; e.irq = i; e.wake = w;
    sb.push_back(e);
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected items and compare to the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() > 0);
      e = sb.pop_front();
      checks++;
      if (flag !== e.flag || irq !== e.irq || wake !== e.wake) begin
        fails++;
        $display("FAIL %s: flag=%b irq=%b wake=%b expected flag=%b irq=%b wake=%b",
                 e.tag, flag, irq, wake, e.flag, e.irq, e.wake);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(2);
    expect_out("R1 in reset", 2'b00, 2'b00, 1'b0);
    rst_n = 1'b1;
    step(5);
    expect_out("R1 after reset", 2'b00, 2'b00, 1'b0);

    // ch0 falling (10), ch1 rising (11)
    en = 2'b11; sense = 4'b1110;
    step(1);
    pin[0] = 1'b0;
    step(2);
    expect_out("R3 not yet at edge 2", 2'b00, 2'b00, 1'b0);
    step(1);
    expect_out("R3 falling flagged at edge 3", 2'b01, 2'b01, 1'b1);
    step(5);
    expect_out("R6 flag sticky", 2'b01, 2'b01, 1'b1);

    // R4: falling on rising-mode ch1 ignored, then rising sets
    pin[1] = 1'b0;
    step(5);
    expect_out("R4 falling ignored", 2'b01, 2'b01, 1'b1);
    pin[1] = 1'b1;
    step(3);
    expect_out("R4 rising flagged", 2'b11, 2'b11, 1'b1);

    // R6 clear
    clr = 2'b01; step(1); clr = 2'b00;
    expect_out("R6 clear ch0", 2'b10, 2'b10, 1'b1);
    clr = 2'b10; step(1); clr = 2'b00;
    expect_out("R6 clear ch1", 2'b00, 2'b00, 1'b0);

    // R3: rising on falling-mode ch0 ignored
    pin[0] = 1'b1;
    step(5);
    expect_out("R3 rising ignored", 2'b00, 2'b00, 1'b0);

    // R7 set wins over simultaneous clear
    pin[0] = 1'b0;
    step(2);
    clr = 2'b01; step(1); clr = 2'b00;
    expect_out("R7 set beats clear", 2'b01, 2'b01, 1'b1);

    // R9 enable gating of flag
    en = 2'b00; #1;
    expect_out("R9 disabled request", 2'b01, 2'b00, 1'b0);
    step(1);
    en = 2'b11; #1;
    expect_out("R9 re-enabled request", 2'b01, 2'b01, 1'b1);
    clr = 2'b01; step(1); clr = 2'b00;
    pin[0] = 1'b1;
    step(5);

    // R5 sense 01 on ch1
    sense = 4'b0110;
    pin[1] = 1'b0; step(5);
    pin[1] = 1'b1; step(5);
    expect_out("R5 off mode no flag", 2'b00, 2'b00, 1'b0);

    // R2 level mode on ch0 with clock halted
    sense = 4'b0100;
    run = 1'b0;
    step(1);
    expect_out("R2 level pin high", 2'b00, 2'b00, 1'b0);
    pin[0] = 1'b0; #1;
    expect_out("R2 level low async", 2'b00, 2'b01, 1'b1);
    en[0] = 1'b0; #1;
    expect_out("R2 level disabled", 2'b00, 2'b00, 1'b0);
    en[0] = 1'b1;
    pin[0] = 1'b1; #1;
    expect_out("R2 level not latched", 2'b00, 2'b00, 1'b0);

    // R8 edge during halt missed
    sense = 4'b0110;
    step(2);
    pin[0] = 1'b0;
    step(4);
    expect_out("R8 halted no flag", 2'b00, 2'b00, 1'b0);
    run = 1'b1;
    step(6);
    expect_out("R8 halted edge not caught on resume", 2'b00, 2'b00, 1'b0);
    pin[0] = 1'b1; step(4);
    pin[0] = 1'b0; step(3);
    expect_out("R8 detection after refill", 2'b01, 2'b01, 1'b1);
    expect_out("R10 wake from edge request", 2'b01, 2'b01, 1'b1);

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule